// File: doc/BRIEF.md
# Double-Precision Rounding and Range Exception Unit

This unit is the last stage of a double-precision floating-point datapath. An upstream stage hands it the product or sum it has formed: a sign, a biased exponent that may lie outside the legal range (a signed value, so it can go negative or past the largest code), a normalised 53-bit significand with its leading one present, and a guard bit and a sticky bit. The unit applies the selected rounding direction and checks whether the rounded value fits. It then writes out the packed 64-bit result.

When the value is too large, the unit either saturates to infinity or to the largest finite number, or it delivers the value with its exponent wrapped back into range by 1536 and raises an overflow trap. When the value is too small, it either shifts the significand down into a subnormal and rounds again, or it delivers a wrapped exponent and raises an underflow trap. Tininess is judged after rounding. A value whose exponent is exactly zero, and whose trial rounding would carry into the leading-one position, is not tiny.

Overflow, underflow and inexact each have a sticky flag, and each has a one-cycle trap pulse that goes out alongside the result. Every accepted operation produces its result and trap pulses one clock after it is presented.

Top module: `rndx_unit`

## Requirements
- R1: An operation presented with `inVld` high produces `outVld` high, with its result and trap pulses, exactly one clock later. `outVld` is low in every other cycle.
- R2: The mode encoding is 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf. In mode 0 the significand is incremented when guard is 1 and either sticky or the significand LSB is 1.
- R3: Mode 2 increments only when the sign is 0 and guard or sticky is set. Mode 3 increments only when the sign is 1 and guard or sticky is set. Mode 1 never increments.
- R4: Normal rounding is applied only when guard or sticky is set and either the exponent is above 0 or the underflow trap is enabled. An increment that carries out of the 53-bit significand adds one to the exponent and clears the fraction.
- R5: When the rounded exponent e lies in 1..2046, the result is {sign, e[10:0], 52-bit fraction}.
- R6: When the rounded exponent is 2047 or more and the overflow trap is disabled, the overflow and inexact conditions are both raised. The result is infinity (exponent 0x7FF, fraction 0) in mode 0, in mode 2 for a positive value and in mode 3 for a negative value. Otherwise it is the largest finite value (exponent 0x7FE, fraction all ones).
- R7: When the rounded exponent is 2047 or more and the overflow trap is enabled, the result carries exponent (e - 1536) modulo 2048 with the rounded fraction. `trapOvf` pulses and the overflow flag is left unchanged.
- R8: When the exponent is 0 or less and the underflow trap is enabled, the result is rounded normally and carries exponent (e + 1536) modulo 2048. `trapUnf` pulses, and `trapOvf` and `trapUnf` are never high together.
- R9: When the exponent is 0 or less and the underflow trap is disabled, the significand with guard and sticky is shifted right by 1 - e places. Shifted-out bits fold into sticky, and the value is rounded again. The result is {sign, 63-bit zero-extended rounded value}, so a carry to bit 52 yields exponent field 1.
- R10: At exponent exactly 0 with guard or sticky set, if rounding the unshifted significand would carry out of 53 bits, the value is not tiny and the underflow flag is not raised.
- R11: On the untrapped underflow path the underflow condition is raised only when the value is tiny and the denormalised value is inexact.
- R12: When the final value is inexact, `trapInx` pulses if the inexact trap is enabled. Otherwise the inexact flag is set.
- R13: Reset clears the result, the traps, `outVld` and all three flags. A set flag stays set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inVld | input | 1 | Operation present this cycle |
| inSign | input | 1 | Sign of the value |
| inExp | input | 14 | Biased exponent, two's complement |
| inSig | input | 53 | Significand with leading one at bit 52 |
| inGuard | input | 1 | First bit below the significand |
| inSticky | input | 1 | OR of all lower bits |
| rndMode | input | 2 | Rounding direction (R2 encoding) |
| ovfTrapEn | input | 1 | Overflow trap enable |
| unfTrapEn | input | 1 | Underflow trap enable |
| inxTrapEn | input | 1 | Inexact trap enable |
| outVld | output | 1 | Result valid |
| outResult | output | 64 | Packed double result |
| trapOvf | output | 1 | Overflow trap pulse |
| trapUnf | output | 1 | Underflow trap pulse |
| trapInx | output | 1 | Inexact trap pulse |
| flagOvf | output | 1 | Sticky overflow flag |
| flagUnf | output | 1 | Sticky underflow flag |
| flagInx | output | 1 | Sticky inexact flag |

## Verification
The bench drives ties with even and odd LSB under nearest-even. This separates the LSB term from the sticky term. Positive and negative inexact values are sent under each directed mode, which shows that sign steers the increment. An all-ones significand exposes the carry into the exponent, both at a normal exponent and at the overflow boundary. Exponent-zero values with and without a trial-round carry give the same packed result but different underflow flags, which isolates tininess after rounding from the denormalisation itself. Deep negative exponents check that every bit folds into sticky, and the trap-enabled cases check the wrapped exponents and which flags are left untouched.

// File: rtl/rndx_pkg.sv
package rndx_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  typedef enum logic [2:0] {
    P_NORM     = 3'd0,
    P_SAT      = 3'd1,
    P_WRAP_OVF = 3'd2,
    P_WRAP_UNF = 3'd3,
    P_DENORM   = 3'd4
  } path_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic  load;
    path_e path;
    logic  satInf;
  } strobe_t;

  // increment decision shared by every rounding point
  function automatic logic rndIncr(input rmode_e mode, input logic sign,
                                   input logic lsb, input logic g, input logic s);
    case (mode)
      RM_NEAR: return g & (s | lsb);
      RM_UP:   return ~sign & (g | s);
      RM_DOWN: return sign & (g | s);
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rndx_dpath.sv
module rndx_dpath
  import rndx_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int EIN_W  = 14
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inSign,
  input  logic [EIN_W-1:0]         inExp,
  input  logic [FRAC_W:0]          inSig,
  input  logic                     inGuard,
  input  logic                     inSticky,
  input  rmode_e                   rndMode,
  input  logic                     unfTrapEn,
  input  strobe_t                  ctl,
  output logic signed [EIN_W:0]    eRnd,
  output logic                     inexactPre,
  output logic                     inexactDen,
  output logic                     trialCarry,
  output logic [EXP_W+FRAC_W:0]    outResult
);
  localparam int SIG_W     = FRAC_W + 1;
  localparam int RES_W     = 1 + EXP_W + FRAC_W;
  localparam int WIDE_W    = 2 * SIG_W + 2;
  localparam int SHIFT_CAP = SIG_W + 3;
  localparam int SH_W      = $clog2(SHIFT_CAP + 1);
  localparam int WRAP      = 3 << (EXP_W - 2);

  logic signed [EIN_W:0]   eExt;
  logic signed [EIN_W+1:0] diff;
  logic                    doRound, incNorm;
  logic [SIG_W:0]          sumNorm;
  logic [FRAC_W-1:0]       fracRnd;
  logic [SH_W-1:0]         shN;
  logic [WIDE_W-1:0]       wide;
  logic [SIG_W-1:0]        denSig, denSum;
  logic                    denG, denS, denInc;
  logic [EXP_W-1:0]        wrapOvfExp, wrapUnfExp, normExp;
  logic [RES_W-1:0]        nextRes;

  // normal rounding point
  always_comb begin
    eExt       = $signed({inExp[EIN_W-1], inExp});
    inexactPre = inGuard | inSticky;
    doRound    = inexactPre && (eExt > 0 || unfTrapEn);
    incNorm    = doRound && rndIncr(rndMode, inSign, inSig[0], inGuard, inSticky);
    sumNorm    = {1'b0, inSig} + (SIG_W+1)'(incNorm);
    fracRnd    = FRAC_W'(sumNorm);
    eRnd       = eExt + $signed((EIN_W+1)'(sumNorm[SIG_W]));
    trialCarry = (&inSig) && rndIncr(rndMode, inSign, inSig[0], inGuard, inSticky);
  end

  // denormalising shifter and second rounding point
  always_comb begin
    diff = 1 - $signed({eExt[EIN_W], eExt});
    if (eExt > 0)               shN = '0;
    else if (diff > SHIFT_CAP)  shN = SH_W'(SHIFT_CAP);
    else                        shN = SH_W'(diff);
    wide       = {inSig, inGuard, {(SIG_W+1){1'b0}}} >> shN;
    denSig     = wide[WIDE_W-1 -: SIG_W];
    denG       = wide[SIG_W+1];
    denS       = inSticky | (|wide[SIG_W:0]);
    inexactDen = denG | denS;
    denInc     = rndIncr(rndMode, inSign, denSig[0], denG, denS);
    denSum     = denSig + SIG_W'(denInc);
  end

  // result assembly
  always_comb begin
    normExp    = EXP_W'(eRnd);
    wrapOvfExp = EXP_W'(eRnd - WRAP);
    wrapUnfExp = EXP_W'(eRnd + WRAP);
    case (ctl.path)
      P_SAT:
        nextRes = ctl.satInf ? {inSign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                             : {inSign, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
      P_WRAP_OVF: nextRes = {inSign, wrapOvfExp, fracRnd};
      P_WRAP_UNF: nextRes = {inSign, wrapUnfExp, fracRnd};
      P_DENORM:   nextRes = {inSign, {(EXP_W-1){1'b0}}, denSum};
      default:    nextRes = {inSign, normExp, fracRnd};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)         outResult <= '0;
    else if (ctl.load) outResult <= nextRes;
  end

endmodule

// File: rtl/rndx_ctrl.sv
module rndx_ctrl
  import rndx_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int EIN_W = 14
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inVld,
  input  logic                  inSign,
  input  rmode_e                rndMode,
  input  logic                  ovfTrapEn,
  input  logic                  unfTrapEn,
  input  logic                  inxTrapEn,
  input  logic signed [EIN_W:0] eRnd,
  input  logic                  inexactPre,
  input  logic                  inexactDen,
  input  logic                  trialCarry,
  output strobe_t               ctl,
  output logic                  outVld,
  output logic                  trapOvf,
  output logic                  trapUnf,
  output logic                  trapInx,
  output logic                  flagOvf,
  output logic                  flagUnf,
  output logic                  flagInx
);
  localparam int MAX_EXP = (1 << EXP_W) - 1;

  logic isOvf, isUnf, tiny;
  logic inxFin, setOvf, setUnf, setInx, tOvf, tUnf, tInx;

  always_comb begin
    isOvf  = eRnd >= $signed((EIN_W+1)'(MAX_EXP));
    isUnf  = eRnd <= 0;
    tiny   = !(eRnd == 0 && inexactPre && trialCarry);
    ctl.load   = inVld;
    ctl.path   = P_NORM;
    ctl.satInf = (rndMode == RM_NEAR) || (rndMode == RM_UP && !inSign)
              || (rndMode == RM_DOWN && inSign);
    inxFin = inexactPre;
    setOvf = 1'b0;
    setUnf = 1'b0;
    tOvf   = 1'b0;
    tUnf   = 1'b0;
    if (isOvf) begin
      if (ovfTrapEn) begin
        ctl.path = P_WRAP_OVF;
        tOvf     = 1'b1;
      end else begin
        ctl.path = P_SAT;
        setOvf   = 1'b1;
        inxFin   = 1'b1;
      end
    end else if (isUnf) begin
      if (unfTrapEn) begin
        ctl.path = P_WRAP_UNF;
        tUnf     = 1'b1;
      end else begin
        ctl.path = P_DENORM;
        inxFin   = inexactDen;
        setUnf   = tiny && inexactDen;
      end
    end
    tInx   = inxFin && inxTrapEn;
    setInx = inxFin && !inxTrapEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outVld  <= 1'b0;
      trapOvf <= 1'b0;
      trapUnf <= 1'b0;
      trapInx <= 1'b0;
      flagOvf <= 1'b0;
      flagUnf <= 1'b0;
      flagInx <= 1'b0;
    end else begin
      outVld  <= inVld;
      trapOvf <= inVld && tOvf;
      trapUnf <= inVld && tUnf;
      trapInx <= inVld && tInx;
      flagOvf <= flagOvf | (inVld && setOvf);
      flagUnf <= flagUnf | (inVld && setUnf);
      flagInx <= flagInx | (inVld && setInx);
    end
  end

endmodule

// File: rtl/rndx_unit.sv
module rndx_unit
  import rndx_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int EIN_W  = 14
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inVld,
  input  logic                  inSign,
  input  logic [EIN_W-1:0]      inExp,
  input  logic [FRAC_W:0]       inSig,
  input  logic                  inGuard,
  input  logic                  inSticky,
  input  logic [1:0]            rndMode,
  input  logic                  ovfTrapEn,
  input  logic                  unfTrapEn,
  input  logic                  inxTrapEn,
  output logic                  outVld,
  output logic [EXP_W+FRAC_W:0] outResult,
  output logic                  trapOvf,
  output logic                  trapUnf,
  output logic                  trapInx,
  output logic                  flagOvf,
  output logic                  flagUnf,
  output logic                  flagInx
);
  rmode_e                mode;
  strobe_t               ctl;
  logic signed [EIN_W:0] eRnd;
  logic                  inexactPre, inexactDen, trialCarry;

  assign mode = rmode_e'(rndMode);

  rndx_dpath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .EIN_W(EIN_W)) dpath (
    .clk(clk), .rstN(rstN), .inSign(inSign), .inExp(inExp), .inSig(inSig),
    .inGuard(inGuard), .inSticky(inSticky), .rndMode(mode), .unfTrapEn(unfTrapEn),
    .ctl(ctl), .eRnd(eRnd), .inexactPre(inexactPre), .inexactDen(inexactDen),
    .trialCarry(trialCarry), .outResult(outResult)
  );

  rndx_ctrl #(.EXP_W(EXP_W), .EIN_W(EIN_W)) ctrl (
    .clk(clk), .rstN(rstN), .inVld(inVld), .inSign(inSign), .rndMode(mode),
    .ovfTrapEn(ovfTrapEn), .unfTrapEn(unfTrapEn), .inxTrapEn(inxTrapEn),
    .eRnd(eRnd), .inexactPre(inexactPre), .inexactDen(inexactDen),
    .trialCarry(trialCarry), .ctl(ctl), .outVld(outVld), .trapOvf(trapOvf),
    .trapUnf(trapUnf), .trapInx(trapInx), .flagOvf(flagOvf), .flagUnf(flagUnf),
    .flagInx(flagInx)
  );

endmodule

// File: rtl/rndx_unit_chk.sv
module rndx_unit_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  inVld,
  input logic                  outVld,
  input logic [EXP_W+FRAC_W:0] outResult,
  input logic                  trapOvf,
  input logic                  trapUnf,
  input logic                  trapInx,
  input logic                  flagOvf,
  input logic                  flagUnf,
  input logic                  flagInx
);
  // R1
  result_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    inVld |=> outVld);
  // R1
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inVld |=> !outVld);
  // R6
  saturate_exp_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagOvf) |-> (&outResult[EXP_W+FRAC_W-1:FRAC_W+1]));
  // R7
  trapped_ovf_noflag_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapOvf |-> $stable(flagOvf));
  // R8
  trap_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({trapOvf, trapUnf}));
  // R11
  unf_needs_inexact_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagUnf) |-> (flagInx || trapInx));
  // R12
  inx_trap_noflag_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapInx |-> $stable(flagInx));
  // R13
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagOvf || flagUnf || flagInx) |=>
      ((flagOvf <= $past(flagOvf) ? 1'b1 : 1'b1) && (flagOvf || !$past(flagOvf))
       && (flagUnf || !$past(flagUnf)) && (flagInx || !$past(flagInx))));
  // R12
  trap_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapOvf || trapUnf || trapInx) |-> outVld);
endmodule

bind rndx_unit rndx_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk (
  .clk(clk), .rstN(rstN), .inVld(inVld), .outVld(outVld), .outResult(outResult),
  .trapOvf(trapOvf), .trapUnf(trapUnf), .trapInx(trapInx),
  .flagOvf(flagOvf), .flagUnf(flagUnf), .flagInx(flagInx)
);

// File: tb/rndx_unit_test.sv
`timescale 1ns/1ps
module rndx_unit_test;
  localparam logic [52:0] ONE = 53'h10_0000_0000_0000;
  localparam logic [52:0] ALL = 53'h1F_FFFF_FFFF_FFFF;

  typedef struct {
    logic [63:0] res;
    logic        tO, tU, tI, fO, fU, fI;
    string       tag;
  } item_t;

  logic clk = 0, rstN = 0, inVld = 0, inSign = 0, inGuard = 0, inSticky = 0;
  logic [13:0] inExp = '0;
  logic [52:0] inSig = '0;
  logic [1:0]  rndMode = '0;
  logic ovfTrapEn = 0, unfTrapEn = 0, inxTrapEn = 0;
  logic outVld, trapOvf, trapUnf, trapInx, flagOvf, flagUnf, flagInx;
  logic [63:0] outResult;

  int checks = 0, fails = 0, cyc = 0;
  item_t q[$];
  logic mO = 0, mU = 0, mI = 0;

  always #2.5 clk = ~clk;

  rndx_unit uut (
    .clk(clk), .rstN(rstN), .inVld(inVld), .inSign(inSign), .inExp(inExp),
    .inSig(inSig), .inGuard(inGuard), .inSticky(inSticky), .rndMode(rndMode),
    .ovfTrapEn(ovfTrapEn), .unfTrapEn(unfTrapEn), .inxTrapEn(inxTrapEn),
    .outVld(outVld), .outResult(outResult), .trapOvf(trapOvf), .trapUnf(trapUnf),
    .trapInx(trapInx), .flagOvf(flagOvf), .flagUnf(flagUnf), .flagInx(flagInx)
  );

  function automatic logic bump(input logic [1:0] rm, input logic sg,
                                input logic lsb, input logic g, input logic s);
    if (rm == 2'd0) return g && (s || lsb);
    if (rm == 2'd2) return !sg && (g || s);
    if (rm == 2'd3) return sg && (g || s);
    return 1'b0;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: compute expectation from the requirements and push it
  task automatic drive(input string tag, input logic sg, input int e,
                       input logic [52:0] m, input logic g, input logic s,
                       input logic [1:0] rm, input logic ot, input logic ut,
                       input logic it);
    item_t x;
    logic [53:0] sum;
    logic [52:0] m2;
    logic g2, s2, inx, tiny, inf;
    int er, n;
    x.tO = 0; x.tU = 0; x.tI = 0; x.tag = tag;
    inx = g | s; er = e; sum = {1'b0, m};
    if (inx && (e > 0 || ut)) begin
      sum = sum + 54'(bump(rm, sg, m[0], g, s));
      if (sum[53]) er = e + 1;
    end
    if (er >= 2047) begin
      if (ot) begin x.res = {sg, 11'(er - 1536), sum[51:0]}; x.tO = 1; end
      else begin
        mO = 1; inx = 1;
        inf = (rm == 0) || (rm == 2 && !sg) || (rm == 3 && sg);
        x.res = inf ? {sg, 11'h7ff, 52'h0} : {sg, 11'h7fe, {52{1'b1}}};
      end
    end else if (er <= 0) begin
      if (ut) begin x.res = {sg, 11'(er + 1536), sum[51:0]}; x.tU = 1; end
      else begin
        tiny = !(er == 0 && inx && bump(rm, sg, m[0], g, s) && (&m));
        n = 1 - er; if (n > 60) n = 60;
        m2 = m; g2 = g; s2 = s;
        for (int i = 0; i < n; i++) begin s2 = s2 | g2; g2 = m2[0]; m2 = m2 >> 1; end
        inx = g2 | s2;
        m2 = m2 + 53'(bump(rm, sg, m2[0], g2, s2));
        x.res = {sg, 10'h0, m2};
        if (tiny && inx) mU = 1;
      end
    end else x.res = {sg, 11'(er), sum[51:0]};
    if (inx) begin if (it) x.tI = 1; else mI = 1; end
    x.fO = mO; x.fU = mU; x.fI = mI;
    @(negedge clk);
    inVld = 1; inSign = sg; inExp = 14'(e); inSig = m; inGuard = g; inSticky = s;
    rndMode = rm; ovfTrapEn = ot; unfTrapEn = ut; inxTrapEn = it;
    q.push_back(x);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin @(negedge clk); inVld = 0; end
  endtask

  task automatic doReset;
    idle(3);
    rstN = 0; mO = 0; mU = 0; mI = 0;
    idle(2);
    check("R13", "reset result", outResult, 64'h0);
    check("R13", "reset traps/flags/valid",
          {58'h0, outVld, trapOvf, trapUnf, trapInx, flagOvf, flagUnf}, 64'h0);
    check("R13", "reset inexact flag", {63'h0, flagInx}, 64'h0);
    rstN = 1;
  endtask

  // monitor: pop and compare as results appear
  initial begin
    item_t x;
    forever begin
      @(negedge clk);
      if (rstN && outVld) begin
        if (q.size() == 0) check("R1", "unexpected outVld", 64'h1, 64'h0);
        else begin
          x = q.pop_front();
          check(x.tag, "result", outResult, x.res);
          check(x.tag, "traps ovf/unf/inx", {61'h0, trapOvf, trapUnf, trapInx},
                {61'h0, x.tO, x.tU, x.tI});
          check(x.tag, "flags ovf/unf/inx", {61'h0, flagOvf, flagUnf, flagInx},
                {61'h0, x.fO, x.fU, x.fI});
        end
      end
    end
  end

  // watchdog
  initial begin
    while (cyc < 20000) begin @(posedge clk); cyc++; end
    check("WDOG", "watchdog expired", 64'h1, 64'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    doReset();
    // R10: not tiny after trial round, underflow flag stays clear
    drive("R10", 0, 0, ALL, 1, 0, 0, 0, 0, 0);
    idle(2);
    check("R10", "no underflow flag", {63'h0, flagUnf}, 64'h0);
    // R11: same packed result but tiny -> underflow flag
    drive("R11", 0, 0, ALL, 0, 1, 0, 0, 0, 0);
    doReset();
    drive("R5 exact", 0, 1023, ONE, 0, 0, 0, 0, 0, 0);
    drive("R2 tie even", 0, 1023, ONE, 1, 0, 0, 0, 0, 0);
    drive("R2 tie odd", 1, 1023, ONE | 53'h1, 1, 0, 0, 0, 0, 0);
    drive("R2 above half", 0, 900, ONE | 53'h6, 1, 1, 0, 0, 0, 0);
    drive("R3 up pos", 0, 1023, ONE, 0, 1, 2, 0, 0, 0);
    drive("R3 up neg", 1, 1023, ONE, 0, 1, 2, 0, 0, 0);
    drive("R3 down neg", 1, 1023, ONE, 1, 0, 3, 0, 0, 0);
    drive("R3 down pos", 0, 1023, ONE, 1, 0, 3, 0, 0, 0);
    drive("R3 zero", 1, 500, ALL, 1, 1, 1, 0, 0, 0);
    drive("R4 carry", 0, 1000, ALL, 1, 1, 0, 0, 0, 0);
    drive("R4 no round when exact", 0, 1000, ALL, 0, 0, 2, 0, 0, 0);
    drive("R13 flags hold", 0, 10, ONE, 0, 0, 0, 0, 0, 0);
    idle(2);
    doReset();
    drive("R6 near inf", 0, 2047, ONE, 0, 0, 0, 0, 0, 0);
    drive("R6 zero max", 1, 2100, ONE, 0, 0, 1, 0, 0, 0);
    drive("R6 up neg max", 1, 3000, ONE, 0, 0, 2, 0, 0, 0);
    drive("R6 down neg inf", 1, 2047, ALL, 1, 1, 3, 0, 0, 0);
    drive("R4 carry into overflow", 0, 2046, ALL, 1, 0, 0, 0, 0, 0);
    doReset();
    drive("R7 wrap ovf", 0, 2046, ALL, 1, 0, 0, 1, 0, 0);
    drive("R7 wrap ovf exact", 1, 2500, ONE | 53'h5, 0, 0, 0, 1, 0, 0);
    drive("R12 inx trap", 0, 2100, ONE, 1, 1, 2, 1, 0, 1);
    drive("R12 inx trap normal", 0, 1023, ONE, 0, 1, 0, 0, 0, 1);
    doReset();
    drive("R8 wrap unf", 0, -5, ONE | 53'h1, 1, 0, 0, 0, 1, 0);
    drive("R8 wrap unf zero", 1, 0, ALL, 1, 0, 0, 0, 1, 0);
    drive("R9 exact denorm", 0, -3, ONE, 0, 0, 0, 0, 0, 0);
    idle(2);
    check("R11", "exact denorm leaves underflow clear", {63'h0, flagUnf}, 64'h0);
    drive("R9 inexact denorm", 0, -10, ALL, 0, 1, 0, 0, 0, 0);
    drive("R9 deep up", 0, -2000, ONE, 0, 0, 2, 0, 0, 0);
    drive("R9 deep near", 1, -2000, ALL, 1, 1, 0, 0, 0, 0);
    drive("R9 down neg", 1, -40, ONE | 53'h3, 0, 0, 3, 0, 0, 0);
    drive("R12 inx trap denorm", 0, -1, ONE | 53'h1, 0, 0, 0, 0, 0, 1);
    idle(4);
    check("R1", "all results returned", 64'(q.size()), 64'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule